// File: doc/BRIEF.md
# Kernel Launch Scratch-Check Sequencer

This block is a control state machine that sits inside a compute command processor. It takes one ready dispatch task at a time. Each task carries a queue number, the byte address of that queue's read pointer, and the number of private (scratch) bytes each work-item needs. The block first reads the word stored right after the read pointer. That word is the read pointer's distance from the start of the queue descriptor, so the block subtracts it to find the descriptor base. It then fetches the whole descriptor and compares the scratch the descriptor grants against the task's demand.

If the grant is enough, the task goes straight to the dispatch output. If it is short and the queue has more than one packet in flight, the scratch area cannot safely be replaced. The block then stops in a sticky error state. In the other shortfall case it writes 1 into the queue's inactive-signal value word, which asks the host runtime for more scratch. It keeps reading that word until the host clears it, then fetches the descriptor again and repeats the check. All memory traffic goes over one request/response port, and only one request is in flight at a time.

Top module: `scratch_launch_seq`

## Requirements
- R1: After reset, task_ready is 1, and busy, err, mem_req and disp_valid are all 0.
- R2: A task is accepted on a clock edge where task_valid and task_ready are both 1. From the next cycle, busy is 1 and task_ready is 0 until the task is dispatched or the block enters the error state.
- R3: The first memory access after acceptance is a read at read-pointer address + RPTR_BYTES. The descriptor base is the read-pointer address minus the returned word.
- R4: Each descriptor fetch reads DESC_WORDS words, from the base upward in steps of DW/8 bytes. The scratch field is the word at byte offset SCR_OFS. The signal handle is the word at byte offset SIG_OFS.
- R5: Available scratch is the scratch field times 1024. When the requested bytes are at most that amount, disp_valid pulses for exactly one cycle. At that pulse, disp_qid holds the task's queue number and disp_base holds the descriptor base.
- R6: On a shortfall with inflight greater than 1, the block makes no write and err goes to 1 and stays 1 until reset. In that state busy and task_ready are 0, no memory request is made, and new tasks are ignored.
- R7: On a shortfall with inflight of 0 or 1, the block writes the value 1 to address signal handle + VAL_OFS.
- R8: After that write, the block reads the same address again after each nonzero response. On a zero response it fetches the whole descriptor again and repeats the check. The cycle of write, poll and fetch repeats until the check passes.
- R9: While mem_req is 1 and no mem_rsp_valid has arrived, mem_addr, mem_we and mem_wdata stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| task_valid | input | 1 | A task is offered |
| task_ready | output | 1 | Block is idle and can take a task |
| task_qid | input | QW | Queue number of the task |
| task_rptr_addr | input | AW | Byte address of the queue read pointer |
| task_priv_bytes | input | DW | Private bytes needed per work-item |
| inflight | input | CW | Packets in flight for this queue |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Request byte address |
| mem_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Response or write acknowledge for the pending request |
| mem_rdata | input | DW | Read data, valid with mem_rsp_valid |
| disp_valid | output | 1 | One-cycle dispatch strobe |
| disp_qid | output | QW | Queue number of the dispatched task |
| disp_base | output | AW | Descriptor base of the dispatched task |
| busy | output | 1 | A task is being processed |
| err | output | 1 | Sticky scratch-reallocation error |

## Verification
The hardest case to reach is the retry loop. It needs the host model to see the signal write, answer a chosen number of polls with a nonzero value, and then update the descriptor's scratch field before the block fetches it again. The bench memory model does exactly this. On the write of 1 it loads a per-case poll count and a new scratch grant. The sweep varies the demand to sit one byte below, exactly at, and one byte above the grant, and varies the poll count and the in-flight value. For every case, the number of descriptor reads, signal writes and polls is predicted from arithmetic alone.

// File: rtl/scratch_launch_seq.sv
module scratch_launch_seq #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int QW         = 6,
  parameter int CW         = 4,
  parameter int DESC_WORDS = 8,
  parameter int RPTR_BYTES = 8,
  parameter int SCR_OFS    = 8,
  parameter int SIG_OFS    = 16,
  parameter int VAL_OFS    = 8,
  parameter int UNIT_SHIFT = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          task_valid,
  output logic          task_ready,
  input  logic [QW-1:0] task_qid,
  input  logic [AW-1:0] task_rptr_addr,
  input  logic [DW-1:0] task_priv_bytes,
  input  logic [CW-1:0] inflight,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rdata,
  output logic          disp_valid,
  output logic [QW-1:0] disp_qid,
  output logic [AW-1:0] disp_base,
  output logic          busy,
  output logic          err
);
  localparam int WB      = DW / 8;
  localparam int IW      = $clog2(DESC_WORDS + 1);
  localparam int SCR_IDX = SCR_OFS / WB;
  localparam int SIG_IDX = SIG_OFS / WB;
  localparam int LAST    = DESC_WORDS - 1;
  localparam int AVW     = DW + UNIT_SHIFT;

  typedef enum logic [2:0] {S_IDLE, S_OFS, S_DESC, S_CHK, S_RAISE, S_POLL, S_ERR} st_t;

  st_t           st;
  logic [IW-1:0] idx;
  logic [QW-1:0] qid_q;
  logic [AW-1:0] rptr_q, base_q, sig_q;
  logic [DW-1:0] priv_q, scr_q;
  logic [AVW-1:0] avail;
  logic          fits;

  assign avail = {scr_q, {UNIT_SHIFT{1'b0}}};
  assign fits  = AVW'(priv_q) <= avail;

  assign task_ready = st == S_IDLE;
  assign busy       = st != S_IDLE && st != S_ERR;
  assign err        = st == S_ERR;
  assign mem_req    = st == S_OFS || st == S_DESC || st == S_RAISE || st == S_POLL;
  assign mem_we     = st == S_RAISE;
  assign mem_wdata  = (st == S_RAISE) ? DW'(1) : '0;
  assign disp_qid   = qid_q;
  assign disp_base  = base_q;

  always_comb begin
    case (st)
      S_OFS:           mem_addr = rptr_q + AW'(RPTR_BYTES);
      S_DESC:          mem_addr = base_q + AW'(idx) * AW'(WB);
      S_RAISE, S_POLL: mem_addr = sig_q + AW'(VAL_OFS);
      default:         mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      idx        <= '0;
      qid_q      <= '0;
      rptr_q     <= '0;
      base_q     <= '0;
      sig_q      <= '0;
      priv_q     <= '0;
      scr_q      <= '0;
      disp_valid <= 1'b0;
    end else begin
      disp_valid <= 1'b0;
      case (st)
        S_IDLE: if (task_valid) begin
          qid_q  <= task_qid;
          rptr_q <= task_rptr_addr;
          priv_q <= task_priv_bytes;
          st     <= S_OFS;
        end
        S_OFS: if (mem_rsp_valid) begin
          base_q <= rptr_q - AW'(mem_rdata);
          idx    <= '0;
          st     <= S_DESC;
        end
        S_DESC: if (mem_rsp_valid) begin
          if (idx == IW'(SCR_IDX)) scr_q <= mem_rdata;
          if (idx == IW'(SIG_IDX)) sig_q <= AW'(mem_rdata);
          if (idx == IW'(LAST)) st <= S_CHK;
          else idx <= idx + 1'b1;
        end
        S_CHK: begin
          if (fits) begin
            disp_valid <= 1'b1;
            st         <= S_IDLE;
          end else if (inflight > CW'(1)) begin
            st <= S_ERR;
          end else begin
            st <= S_RAISE;
          end
        end
        S_RAISE: if (mem_rsp_valid) st <= S_POLL;
        S_POLL: if (mem_rsp_valid && mem_rdata == '0) begin
          idx <= '0;
          st  <= S_DESC;
        end
        default: st <= S_ERR;
      endcase
    end
  end
endmodule

module scratch_launch_seq_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          task_valid,
  input logic          task_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_rsp_valid,
  input logic          disp_valid,
  input logic          busy,
  input logic          err
);
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n) err |=> err);
  a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n) err |-> !mem_req && !busy && !task_ready);
  a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n) task_ready |-> !busy && !err);
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n) task_valid && task_ready |=> busy);
  a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rsp_valid |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  a_r7_write_one: assert property (@(posedge clk) disable iff (!rst_n) mem_req && mem_we |-> mem_wdata == DW'(1));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n) disp_valid |=> !disp_valid);
  a_r5_no_err_on_disp: assert property (@(posedge clk) disable iff (!rst_n) disp_valid |-> !err);
endmodule

bind scratch_launch_seq scratch_launch_seq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/scratch_launch_seq_tb.sv
module scratch_launch_seq_tb_top;
  localparam int AW = 32, DW = 32, QW = 6, CW = 4, DW_N = 8, LAT = 2;
  localparam logic [31:0] OFS = 32'h40, SIG = 32'h8000, SIGV = SIG + 32'd8;

  logic clk = 0, rst_n = 0;
  logic task_valid = 0, task_ready;
  logic [QW-1:0] task_qid = '0;
  logic [AW-1:0] task_rptr_addr = '0;
  logic [DW-1:0] task_priv_bytes = '0;
  logic [CW-1:0] inflight = '0;
  logic mem_req, mem_we, mem_rsp_valid = 0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;
  logic disp_valid, busy, err;
  logic [QW-1:0] disp_qid;
  logic [AW-1:0] disp_base;

  always #4 clk = ~clk;

  scratch_launch_seq #(.AW(AW), .DW(DW), .QW(QW), .CW(CW), .DESC_WORDS(DW_N)) dut_i (.*);

  int tests = 0, fails = 0;
  logic clr = 0;
  logic [31:0] cur_scr = 0, new_scr = 0, polls_target = 0, poll_left = 0, base_m = 0;
  int desc_rd, wr_cnt, wr_bad, poll_cnt, first_bad, nreq, hold_bad, cnt;
  logic [AW-1:0] pend_addr;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (clr) begin
      desc_rd <= 0; wr_cnt <= 0; wr_bad <= 0; poll_cnt <= 0;
      first_bad <= 0; nreq <= 0; hold_bad <= 0; cnt <= 0;
    end else if (mem_req && !mem_rsp_valid) begin
      if (cnt == 0) begin
        pend_addr <= mem_addr;
        if (nreq == 0 && (mem_we || mem_addr != task_rptr_addr + 32'd8)) first_bad <= first_bad + 1;
        nreq <= nreq + 1;
      end else if (mem_addr != pend_addr) hold_bad <= hold_bad + 1;
      if (cnt == LAT) begin
        cnt <= 0;
        mem_rsp_valid <= 1'b1;
        mem_rdata <= 32'hdead0000 | (mem_addr & 32'hffff);
        if (mem_we) begin
          wr_cnt <= wr_cnt + 1;
          if (mem_addr != SIGV || mem_wdata != 1) wr_bad <= wr_bad + 1;
          poll_left <= polls_target;
          cur_scr <= new_scr;
        end else if (mem_addr == task_rptr_addr + 32'd8) mem_rdata <= OFS;
        else if (mem_addr == SIGV) begin
          poll_cnt <= poll_cnt + 1;
          if (poll_left != 0) begin mem_rdata <= poll_left; poll_left <= poll_left - 1; end
          else mem_rdata <= 0;
        end else if (mem_addr >= base_m && mem_addr < base_m + DW_N * 4) begin
          desc_rd <= desc_rd + 1;
          if (mem_addr == base_m + 8) mem_rdata <= cur_scr;
          if (mem_addr == base_m + 16) mem_rdata <= SIG;
        end
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; task_valid = 0; clr = 1;
    repeat (3) @(negedge clk);
    rst_n = 1; clr = 0;
    @(negedge clk);
  endtask

  task automatic run_case(int qid, int scr0, int scrn, int priv, int infl, int p);
    logic [31:0] rp;
    bit ok0, done;
    rp = 32'h1000 + 32'(qid) * 32'h100;
    base_m = rp - OFS;
    cur_scr = scr0; new_scr = scrn; polls_target = p;
    clr = 1; @(negedge clk); clr = 0;
    task_qid = QW'(qid); task_rptr_addr = rp; task_priv_bytes = priv; inflight = CW'(infl);
    task_valid = 1;
    @(negedge clk);
    task_valid = 0;
    chk("R2 busy after accept", busy, 1);
    chk("R2 ready low", task_ready, 0);
    done = 0;
    for (int i = 0; i < 3000 && !done; i++) begin
      if (disp_valid || err) done = 1; else @(negedge clk);
    end
    chk("R3 first access at rptr+8", first_bad, 0);
    chk("R9 request held", hold_bad, 0);
    ok0 = priv <= scr0 * 1024;
    if (ok0) begin
      chk("R5 dispatch", disp_valid, 1);
      chk("R5 qid", disp_qid, qid);
      chk("R3 base", disp_base, base_m);
      chk("R4 desc reads", desc_rd, DW_N);
      chk("R5 no write", wr_cnt, 0);
    end else if (infl > 1) begin
      chk("R6 err", err, 1);
      chk("R6 no write", wr_cnt, 0);
      chk("R6 busy low", busy, 0);
    end else begin
      chk("R8 dispatch after retry", disp_valid, 1);
      chk("R8 base", disp_base, base_m);
      chk("R7 one write", wr_cnt, 1);
      chk("R7 write addr/data", wr_bad, 0);
      chk("R8 polls", poll_cnt, p + 1);
      chk("R8 desc reread", desc_rd, 2 * DW_N);
    end
    @(negedge clk);
    if (!err) begin
      chk("R5 pulse ends", disp_valid, 0);
      chk("R2 idle again", task_ready && !busy, 1);
    end
  endtask

  initial begin
    do_reset();
    chk("R1 ready", task_ready, 1);
    chk("R1 busy", busy, 0);
    chk("R1 err", err, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 disp_valid", disp_valid, 0);
    for (int s = 1; s <= 3; s++)
      for (int d = -1; d <= 1; d++)
        for (int f = 0; f <= 1; f++)
          run_case(s + 4 * f, s, s + 1, s * 1024 + d, f, (s + d + 1) % 3);
    run_case(9, 0, 1, 0, 1, 0);
    run_case(10, 2, 5, 4096, 1, 2);
    run_case(11, 1, 9, 1025, 2, 0);
    chk("R6 sticky", err, 1);
    task_valid = 1;
    repeat (20) @(negedge clk);
    task_valid = 0;
    chk("R6 still err", err, 1);
    chk("R6 ready low", task_ready, 0);
    chk("R6 no mem", mem_req, 0);
    do_reset();
    chk("R1 err cleared", err, 0);
    run_case(12, 1, 2, 1025, 3, 0);
    chk("R6 err inflight 3", err, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule